// File: doc/BRIEF.md
# Dual-Edge Strobe Burst Receiver with CRC-16 Check

This block receives a synchronous DMA burst. A transmitter drives 16-bit words onto a data bus and toggles a strobe, and both the rising and the falling strobe edge carry a word. The block runs from a local system clock. It oversamples the strobe, the data bus and an active-low acknowledge through synchronizer flops, finds strobe transitions on the synchronized copy, and hands each captured word to the local side with a single-cycle valid pulse. The system clock must run at least four times faster than the strobe toggle rate. Data must be stable for two system clocks before each strobe transition and must not change before the next transition.

The acknowledge marks a burst segment. While it is low, every captured word also updates a running CRC-16. When the acknowledge rises, the block takes the word on the bus as the transmitter's CRC and compares it with its own value. A mismatch sets an error flag. The flag stays set until the next segment opens.

Flow control comes from a small receive FIFO that reports its free entry count. The block lowers its ready output early, so that words already in flight after a pause request still fit in the FIFO.

Top module: `strobe_burst_rx`

## Requirements
- R1: Each transition of `strb`, rising or falling, while `ack_n` is low yields exactly one `word_vld` pulse one clock long. `word_out` carries the bus value that was present at that transition. Words leave in arrival order, and `word_vld` rises on the third clock edge after the transition.
- R2: While `strb` stays at a constant level, high or low, `word_vld` stays low for any duration. Capture resumes with the next transition.
- R3: The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1) and is seeded to 0xFFFF each time `ack_n` falls. Each word shifts in most significant bit first. A segment with no words therefore expects the CRC word 0xFFFF.
- R4: Strobe transitions while `ack_n` is high produce no `word_vld` pulse and do not enter the CRC.
- R5: When `ack_n` rises, the bus value at that moment is compared with the local CRC. `crc_err` becomes 1 on a mismatch and 0 on a match.
- R6: `crc_err` keeps its value until the next falling edge of `ack_n`, which clears it.
- R7: `rx_ready` is 1 exactly when `fifo_free` was greater than 2 at the previous clock edge. It is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb | input | 1 | Transmitter strobe, asynchronous, data on both edges |
| dbus | input | 16 | Transmitter data bus, asynchronous |
| ack_n | input | 1 | Active-low acknowledge that frames a burst segment |
| fifo_free | input | 5 | Free entry count of the receive FIFO |
| word_out | output | 16 | Captured data word |
| word_vld | output | 1 | One-cycle pulse, word_out valid |
| rx_ready | output | 1 | Receiver ready, 0 asks the transmitter to pause |
| crc_err | output | 1 | CRC mismatch of the last closed segment |

## Verification
The assertions check the following on every cycle, against the input ports. A valid pulse follows a strobe transition seen while the acknowledge was low. The error flag only rises when a segment closes and only clears when a new one opens. The ready output tracks the free-count threshold. Only the bench scenarios can show the rest, because it depends on the whole burst. This covers the CRC value itself, including the reseed between segments and the empty-segment case, and it covers that long steady-strobe pauses and transitions outside a segment leave the output stream and the CRC untouched.

// File: rtl/strobe_burst_rx.sv
module strobe_burst_rx #(
  parameter int          DW       = 16,
  parameter int          FREE_W   = 5,
  parameter int          SLACK    = 2,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb,
  input  logic [DW-1:0] dbus,
  input  logic          ack_n,
  input  logic [FREE_W-1:0] fifo_free,
  output logic [DW-1:0] word_out,
  output logic          word_vld,
  output logic          rx_ready,
  output logic          crc_err
);

  logic [2:0]    st_q;
  logic [2:0]    ak_q;
  logic [DW-1:0] d1_q, d2_q;
  logic [15:0]   crc_q;

  wire in_seg  = ~ak_q[1];
  wire stb_evt = (st_q[1] ^ st_q[2]) & in_seg;
  wire seg_open  = ak_q[2] & ~ak_q[1];
  wire seg_close = ~ak_q[2] & ak_q[1];

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [DW-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      ak_q <= '1;
      d1_q <= '0;
      d2_q <= '0;
    end else begin
      st_q <= {st_q[1:0], strb};
      ak_q <= {ak_q[1:0], ack_n};
      d1_q <= dbus;
      d2_q <= d1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
      word_vld <= 1'b0;
      crc_q    <= CRC_SEED;
      crc_err  <= 1'b0;
      rx_ready <= 1'b0;
    end else begin
      word_vld <= stb_evt;
      rx_ready <= fifo_free > FREE_W'(SLACK);
      if (stb_evt) begin
        word_out <= d2_q;
        crc_q    <= crc_next(crc_q, d2_q);
      end
      if (seg_open) begin
        crc_q   <= CRC_SEED;
        crc_err <= 1'b0;
      end else if (seg_close) begin
        crc_err <= d2_q[15:0] != crc_q;
      end
    end
  end

  a_r1_vld_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ($past(strb, 3) != $past(strb, 4)));
  a_r4_vld_only_in_segment: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ($past(ack_n, 3) == 1'b0));
  a_r5_err_rises_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> ($past(ack_n, 3) == 1'b1));
  a_r6_err_clears_at_open: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crc_err) |-> ($past(ack_n, 3) == 1'b0));
  a_r7_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_free <= FREE_W'(SLACK)) |=> !rx_ready);
  a_r7_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_free > FREE_W'(SLACK)) |=> rx_ready);

endmodule

// File: tb/tb_strobe_burst_rx.sv
module tb_strobe_burst_rx;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        strb = 0;
  logic [15:0] dbus = 0;
  logic        ack_n = 1;
  logic [4:0]  fifo_free = 5'd8;
  logic [15:0] word_out;
  logic        word_vld, rx_ready, crc_err;

  int checks = 0, fails = 0;
  bit done = 0;
  bit in_seg = 0;
  logic [15:0] expq[$];
  int model_crc = 16'hFFFF;

  always #10 clk = ~clk;

  strobe_burst_rx dut (.clk(clk), .rst_n(rst_n), .strb(strb), .dbus(dbus), .ack_n(ack_n),
    .fifo_free(fifo_free), .word_out(word_out), .word_vld(word_vld), .rx_ready(rx_ready),
    .crc_err(crc_err));

  function automatic int ref_crc(int c, int w);
    for (int b = 15; b >= 0; b--) begin
      int top = (c >> 15) & 1;
      int bit_in = (w >> b) & 1;
      c = (c << 1) & 16'hFFFF;
      if ((top ^ bit_in) != 0) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(rx_ready == (fifo_free > 2), "R7 ready", rx_ready, fifo_free > 2);
      if (word_vld) begin
        if (expq.size() == 0) check(0, "R2/R4 unexpected word", word_out, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(word_out == e, "R1 word", word_out, e);
        end
      end
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    dbus = w;
    clocks(2);
    strb = ~strb;
    if (in_seg) begin
      expq.push_back(w);
      model_crc = ref_crc(model_crc, w);
    end
    clocks(4);
  endtask

  task automatic open_seg;
    ack_n = 0;
    in_seg = 1;
    model_crc = 16'hFFFF;
    clocks(5);
  endtask

  task automatic close_seg(input logic [15:0] crc_word);
    dbus = crc_word;
    clocks(2);
    ack_n = 1;
    in_seg = 0;
    clocks(5);
    check(expq.size() == 0, "R1 all words delivered", expq.size(), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clocks(3);
    check(word_vld == 0, "R1 reset vld", word_vld, 0);
    check(crc_err == 0, "R5 reset err", crc_err, 0);
    check(rx_ready == 0, "R7 reset ready", rx_ready, 0);
    rst_n = 1;
    clocks(3);

    // R4: transitions outside a segment are ignored
    send(16'hDEAD); send(16'hBEEF);
    clocks(5);

    // R1 R3 R5: good burst
    open_seg();
    for (int i = 0; i < 8; i++) send(16'h1111 * i + 16'h0F0F);
    close_seg(model_crc[15:0]);
    check(crc_err == 0, "R5 good crc", crc_err, 0);

    // R2: long pauses at both levels inside a burst
    open_seg();
    send(16'hA5A5);
    clocks(40);
    send(16'h5A5A);
    clocks(40);
    send(16'hFFFF); send(16'h0000);
    close_seg(model_crc[15:0]);
    check(crc_err == 0, "R2 paused burst crc", crc_err, 0);

    // R5 R6: bad crc, held
    open_seg();
    send(16'h1234); send(16'h8001);
    close_seg(model_crc[15:0] ^ 16'h0001);
    check(crc_err == 1, "R5 bad crc", crc_err, 1);
    send(16'h7777);
    clocks(30);
    check(crc_err == 1, "R6 err held", crc_err, 1);
    open_seg();
    check(crc_err == 0, "R6 err cleared at open", crc_err, 0);
    // R3: reseed, same words as the first burst
    for (int i = 0; i < 8; i++) send(16'h1111 * i + 16'h0F0F);
    close_seg(model_crc[15:0]);
    check(crc_err == 0, "R3 reseed", crc_err, 0);

    // R3: empty segment expects the seed
    open_seg();
    close_seg(16'hFFFF);
    check(crc_err == 0, "R3 empty seg", crc_err, 0);
    open_seg();
    close_seg(16'h0000);
    check(crc_err == 1, "R3 empty seg wrong", crc_err, 1);

    // R3: single word, known value
    open_seg();
    send(16'h0000);
    close_seg(16'(ref_crc(16'hFFFF, 0)));
    check(crc_err == 0, "R3 single word", crc_err, 0);

    // R7: threshold sweep
    for (int f = 0; f < 8; f++) begin
      fifo_free = 5'(f);
      clocks(3);
    end
    fifo_free = 5'd31;
    clocks(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule